// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Driver-Enable Sequencing

This block serialises bytes onto an asynchronous line and drives the transmit-enable pin of a half-duplex bus transceiver. Every frame is wrapped in a driver-enable window. The window opens a programmable number of sample ticks before the start bit. It closes a programmable number of sample ticks after the stop bit ends. Timing is counted only on cycles where the external sample-rate tick is high. A bit spans 16 ticks, or 8 ticks when the 8x oversampling option is chosen.

Software-side logic writes bytes through a valid/ready handshake into a single holding register. When a byte waits while a frame is still going out, it follows the current frame without DE dropping. First the whole lag interval runs. Then a fresh lead interval runs, and only after that does the next start bit begin. The lead time, the lag time and the oversampling option can be loaded only while the block is disabled. A completion flag tells the host when the bus has been released and nothing remains to send.

Top module: `uart_de_tx`

## Requirements
- R1: After reset, tx is 1, de is 0, tc is 0, wready is 0 while enable is 0, and the lead time, lag time and oversampling option are all 0. wready is 1 once enable is 1.
- R2: A frame is one start bit at 0, then the 8 data bits least significant bit first, then one stop bit at 1. Each bit lasts 16 ticks when cfg_os8 was loaded as 0, and 8 ticks when it was loaded as 1.
- R3: de rises lead ticks before the start bit begins. When lead is 0, de rises in the same cycle as tx falls for the start bit.
- R4: de falls lag ticks after the stop bit ends. When lag is 0, de falls at the end of the stop bit. de changes only after a tick or on disable.
- R5: A byte accepted during the lag interval leaves the remaining lag untouched. Once the lag expires, a full lead interval runs, then the frame starts. de stays 1 throughout.
- R6: A byte accepted while a frame is shifting goes out after that frame's lag and a new lead. de stays 1 across both frames.
- R7: wready equals enable with an empty holding register. It falls in the cycle after an accepted write and rises in the cycle after the byte moves into the shifter.
- R8: cfg_we loads cfg_lead, cfg_lag and cfg_os8 only while enable is 0. While enable is 1, cfg_we has no effect on later frame timing.
- R9: In the cycle after enable goes to 0, tx is 1, de is 0, tc is 0 and wready is 0. A byte waiting in the holding register is discarded and is never sent after re-enable.
- R10: tc is set when de falls with no byte waiting, and cleared by the next accepted write. If a write is accepted in the same cycle that the lag expires, tc stays 0 and de still falls.
- R11: tx is 0 only while de is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low forces the line idle |
| tick | input | 1 | Sample-rate tick, one cycle wide |
| cfg_we | input | 1 | Loads the timing fields while disabled |
| cfg_os8 | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| cfg_lead | input | 5 | DE lead time in ticks |
| cfg_lag | input | 5 | DE lag time in ticks |
| wvalid | input | 1 | Write data valid |
| wdata | input | 8 | Byte to transmit |
| wready | output | 1 | Holding register can accept a byte |
| tx | output | 1 | Serial line, idles high |
| de | output | 1 | Driver enable for the bus transceiver |
| tc | output | 1 | Transmission complete |

## Verification
The close call is a write being accepted in the same cycle that the lag counter expires. In that cycle, the completion flag is asked to be set and cleared at once, and the controller must decide whether a byte is pending. The bench uses a tick on every cycle and its reference model to find the exact cycle where the lag runs out. It asserts wvalid just before that edge. It then expects de low and tc low after the edge, followed by a new lead and frame. A second collision is a write landing during the lag interval. There, de must stay high through the remaining lag and a full lead, which is judged by counting the ticks spent with de high.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LAG   = 2'd3
  } de_state_t;

  // Sample ticks in one bit period for the selected oversampling rate.
  function automatic int bit_ticks(input logic os8);
    return os8 ? 8 : 16;
  endfunction

  // Ticks between DE rise and DE fall for a lone frame.
  function automatic int window_ticks(input logic os8, input int lead, input int lag, input int data_w);
    return lead + (data_w + 2) * bit_ticks(os8) + lag;
  endfunction

endpackage

// File: rtl/uart_de_cfg.sv
module uart_de_cfg #(
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic              os8_in,
  input  logic [TIME_W-1:0] lead_in,
  input  logic [TIME_W-1:0] lag_in,
  output logic              os8_q,
  output logic [TIME_W-1:0] lead_q,
  output logic [TIME_W-1:0] lag_q
);

  logic cfg_load;
  assign cfg_load = cfg_we && !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os8_q  <= 1'b0;
      lead_q <= '0;
      lag_q  <= '0;
    end else if (cfg_load) begin
      os8_q  <= os8_in;
      lead_q <= lead_in;
      lag_q  <= lag_in;
    end
  end

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(lead_q) && $stable(lag_q) && $stable(os8_q)));

endmodule

// File: rtl/uart_de_hold.sv
module uart_de_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  output logic              wready,
  output logic              accept,
  output logic              pend,
  output logic [DATA_W-1:0] data_q
);

  assign wready = enable && !pend;
  assign accept = wvalid && wready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      data_q <= '0;
    end else if (!enable) begin
      pend   <= 1'b0;
    end else if (accept) begin
      pend   <= 1'b1;
      data_q <= wdata;
    end else if (load) begin
      pend   <= 1'b0;
    end
  end

  // R7
  ready_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wready);

  // R7
  ready_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && enable) |=> wready);

endmodule

// File: rtl/uart_de_ctrl.sv
module uart_de_ctrl
  import uart_de_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              os8,
  input  logic [TIME_W-1:0] lead,
  input  logic [TIME_W-1:0] lag,
  input  logic              pend,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  output logic              load,
  output logic              tx,
  output logic              de,
  output logic              tc
);

  localparam int CNT_W = (TIME_W > 5) ? TIME_W : 5;
  localparam int BC_W  = $clog2(DATA_W + 2);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W + 1);

  de_state_t         state, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n, bit_m1;
  logic [BC_W-1:0]   bitcnt, bit_n;
  logic [DATA_W:0]   shreg, sh_n;
  logic              tx_n, de_n;

  // Named internal events
  logic frame_end, lag_done, after_lag, launch, start_frame, tc_set;

  assign bit_m1 = CNT_W'(bit_ticks(os8) - 1);

  always_comb begin
    st_n        = state;
    cnt_n       = cnt;
    bit_n       = bitcnt;
    sh_n        = shreg;
    tx_n        = tx;
    de_n        = de;
    frame_end   = 1'b0;
    lag_done    = 1'b0;
    after_lag   = 1'b0;
    launch      = 1'b0;
    start_frame = 1'b0;
    tc_set      = 1'b0;
    if (tick) begin
      case (state)
        ST_IDLE:  launch = pend;
        ST_LEAD:  if (cnt == '0) start_frame = 1'b1; else cnt_n = cnt - 1'b1;
        ST_SHIFT: begin
          if (cnt != '0) begin
            cnt_n = cnt - 1'b1;
          end else if (bitcnt == BIT_LAST) begin
            frame_end = 1'b1;
          end else begin
            tx_n  = shreg[0];
            sh_n  = shreg >> 1;
            bit_n = bitcnt + 1'b1;
            cnt_n = bit_m1;
          end
        end
        ST_LAG:   if (cnt == '0) lag_done = 1'b1; else cnt_n = cnt - 1'b1;
        default:  st_n = ST_IDLE;
      endcase
    end
    if (frame_end) begin
      if (lag != '0) begin
        st_n  = ST_LAG;
        cnt_n = CNT_W'(lag - 1'b1);
      end else begin
        after_lag = 1'b1;
      end
    end
    if (lag_done) after_lag = 1'b1;
    if (after_lag) begin
      if (pend) begin
        launch = 1'b1;
      end else begin
        st_n   = ST_IDLE;
        de_n   = 1'b0;
        tc_set = 1'b1;
      end
    end
    if (launch) begin
      de_n = 1'b1;
      if (lead != '0) begin
        st_n  = ST_LEAD;
        cnt_n = CNT_W'(lead - 1'b1);
      end else begin
        start_frame = 1'b1;
      end
    end
    if (start_frame) begin
      st_n  = ST_SHIFT;
      tx_n  = 1'b0;
      de_n  = 1'b1;
      sh_n  = {1'b1, data};
      bit_n = '0;
      cnt_n = bit_m1;
    end
  end

  assign load = start_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitcnt <= '0;
      shreg  <= '1;
      tx     <= 1'b1;
      de     <= 1'b0;
      tc     <= 1'b0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitcnt <= '0;
      tx     <= 1'b1;
      de     <= 1'b0;
      tc     <= 1'b0;
    end else begin
      state  <= st_n;
      cnt    <= cnt_n;
      bitcnt <= bit_n;
      shreg  <= sh_n;
      tx     <= tx_n;
      de     <= de_n;
      if (accept)      tc <= 1'b0;
      else if (tc_set) tc <= 1'b1;
    end
  end

  // R11
  tx_low_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx |-> de);

  // R10
  tc_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> !de);

  // R7
  load_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> pend);

  // R4
  de_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de) |-> ($past(tick) || !$past(enable)));

  // R2
  start_bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx) |-> (de && $past(tick)));

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx #(
  parameter int DATA_W = 8,
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic              cfg_os8,
  input  logic [TIME_W-1:0] cfg_lead,
  input  logic [TIME_W-1:0] cfg_lag,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  output logic              wready,
  output logic              tx,
  output logic              de,
  output logic              tc
);

  logic              os8_q;
  logic [TIME_W-1:0] lead_q, lag_q;
  logic              load, accept, pend;
  logic [DATA_W-1:0] hold_data;

  uart_de_cfg #(.TIME_W(TIME_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .os8_in(cfg_os8), .lead_in(cfg_lead), .lag_in(cfg_lag),
    .os8_q(os8_q), .lead_q(lead_q), .lag_q(lag_q)
  );

  uart_de_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wvalid(wvalid), .wdata(wdata),
    .load(load), .wready(wready), .accept(accept), .pend(pend), .data_q(hold_data)
  );

  uart_de_ctrl #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .os8(os8_q),
    .lead(lead_q), .lag(lag_q), .pend(pend), .accept(accept), .data(hold_data),
    .load(load), .tx(tx), .de(de), .tc(tc)
  );

endmodule

// File: tb/uart_de_tx_bench.sv
module uart_de_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_os8 = 1'b0;
  logic [4:0] cfg_lead = '0;
  logic [4:0] cfg_lag = '0;
  logic       wvalid = 1'b0;
  logic [7:0] wdata = '0;
  logic       wready, tx, de, tc;

  always #2.5 clk = ~clk;

  uart_de_tx u_uart_de_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .cfg_we(cfg_we),
    .cfg_os8(cfg_os8), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag), .wvalid(wvalid),
    .wdata(wdata), .wready(wready), .tx(tx), .de(de), .tc(tc)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Tick generator: one tick every tick_every cycles
  int tick_every = 2;
  int tcount = 0;
  always @(negedge clk) begin
    tcount++;
    tick = ((tcount % tick_every) == 0);
  end

  // Behavioural reference model
  int   m_phase = 0;      // 0 idle, 1 lead, 2 frame, 3 lag
  int   m_rem = 0;
  int   m_el = 0;
  logic [7:0] m_byte;
  logic [7:0] m_q[$];
  int   m_lead = 0, m_lag = 0, m_bl = 16;
  logic m_tx = 1, m_de = 0, m_tc = 0;
  int   de_ticks = 0;
  bit   tc_set;

  function automatic logic line_bit(int idx);
    if (idx == 0) return 1'b0;
    if (idx >= 9) return 1'b1;
    return m_byte[idx-1];
  endfunction

  task automatic m_begin_frame();
    m_byte = m_q.pop_front();
    m_el = 0; m_phase = 2; m_tx = 0; m_de = 1;
  endtask

  task automatic m_start_next();
    m_de = 1;
    if (m_lead > 0) begin m_phase = 1; m_rem = m_lead - 1; end
    else m_begin_frame();
  endtask

  task automatic m_after_lag();
    if (m_q.size() != 0) m_start_next();
    else begin m_phase = 0; m_de = 0; tc_set = 1; end
  endtask

  always @(posedge clk) begin
    bit acc;
    acc = wvalid && enable && (m_q.size() == 0);
    if (rst_n && tick && de) de_ticks++;
    tc_set = 0;
    if (!rst_n) begin
      m_phase = 0; m_q.delete(); m_tx = 1; m_de = 0; m_tc = 0;
      m_lead = 0; m_lag = 0; m_bl = 16;
    end else if (!enable) begin
      m_phase = 0; m_q.delete(); m_tx = 1; m_de = 0; m_tc = 0;
      if (cfg_we) begin m_lead = cfg_lead; m_lag = cfg_lag; m_bl = cfg_os8 ? 8 : 16; end
    end else begin
      if (tick) begin
        case (m_phase)
          0: if (m_q.size() != 0) m_start_next();
          1: if (m_rem == 0) m_begin_frame(); else m_rem--;
          2: begin
            m_el++;
            if (m_el == 10 * m_bl) begin
              if (m_lag > 0) begin m_phase = 3; m_rem = m_lag - 1; end
              else m_after_lag();
            end else m_tx = line_bit(m_el / m_bl);
          end
          default: if (m_rem == 0) m_after_lag(); else m_rem--;
        endcase
      end
      if (acc) m_q.push_back(wdata);
      if (acc) m_tc = 0; else if (tc_set) m_tc = 1;
    end
  end

  // Cycle-by-cycle comparison, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2", "tx", tx, m_tx);
      check(cur_req, "de", de, m_de);
      check("R10", "tc", tc, m_tc);
      check("R7", "wready", wready, enable && (m_q.size() == 0));
      if (!tx) check("R11", "de while tx low", de, 1);
    end
  end

  task automatic set_cfg(input int ld, input int lg, input bit o8);
    @(negedge clk); enable = 0; cfg_we = 1; cfg_lead = 5'(ld); cfg_lag = 5'(lg); cfg_os8 = o8;
    @(negedge clk); cfg_we = 0; enable = 1;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); wvalid = 1; wdata = b;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(m_phase == 0 && m_q.size() == 0 && !de)) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "tx in reset", tx, 1);
    check("R1", "de in reset", de, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "tc after reset", tc, 0);
    check("R1", "wready disabled", wready, 0);
    enable = 1;
    @(negedge clk);
    check("R1", "wready enabled", wready, 1);

    // R1: zero fields by default -> window is exactly one frame at 16x
    cur_req = "R3"; de_ticks = 0;
    send(8'h3C); wait_idle();
    check("R1", "default window ticks", de_ticks, 160);

    // R3 R4 R2: lead 3, lag 5, 16x
    set_cfg(3, 5, 0); de_ticks = 0; cur_req = "R4";
    send(8'hA5); wait_idle();
    check("R4", "de window ticks lead3 lag5", de_ticks, 168);
    check("R10", "tc after frame", tc, 1);

    // R2 at 8x with zero intervals
    set_cfg(0, 0, 1); de_ticks = 0; cur_req = "R3";
    send(8'h81); wait_idle();
    check("R2", "de window ticks 8x", de_ticks, 80);

    // R6 back-to-back during shift
    de_ticks = 0; cur_req = "R6";
    send(8'h5A); send(8'hC3);
    check("R10", "tc cleared by write", tc, 0);
    wait_idle();
    check("R6", "de window two frames", de_ticks, 160);

    // R5 write during lag
    set_cfg(4, 6, 1); de_ticks = 0; cur_req = "R5";
    send(8'h0F);
    @(negedge clk);
    while (m_phase != 3) @(negedge clk);
    send(8'hF0); wait_idle();
    check("R5", "de window lag then lead", de_ticks, 180);

    // R8 config write while enabled is ignored
    cur_req = "R8";
    @(negedge clk); cfg_we = 1; cfg_lead = 5'd20; cfg_lag = 5'd20; cfg_os8 = 0;
    @(negedge clk); cfg_we = 0;
    de_ticks = 0;
    send(8'h66); wait_idle();
    check("R8", "window unchanged by enabled cfg_we", de_ticks, 90);

    // R10 collision: write accepted in the cycle the lag expires
    tick_every = 1; set_cfg(2, 3, 1); cur_req = "R10";
    send(8'h99);
    @(negedge clk);
    while (!(m_phase == 3 && m_rem == 0)) @(negedge clk);
    wvalid = 1; wdata = 8'h42;
    check("R10", "wready at collision", wready, 1);
    @(negedge clk); wvalid = 0;
    check("R10", "tc held low on collision", tc, 0);
    check("R4", "de falls at lag end", de, 0);
    wait_idle();
    check("R10", "tc after second frame", tc, 1);

    // R9 disable mid-frame with a byte waiting
    tick_every = 2; set_cfg(2, 2, 0); cur_req = "R9";
    send(8'hE7); send(8'h18);
    repeat (40) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check("R9", "tx idle on disable", tx, 1);
    check("R9", "de idle on disable", de, 0);
    check("R9", "wready on disable", wready, 0);
    check("R9", "tc on disable", tc, 0);
    enable = 1;
    repeat (100) @(negedge clk);
    check("R9", "pending byte discarded", de, 0);
    check("R9", "line idle after re-enable", tx, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule